// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block steps endpoint zero of a USB device through the data and status stages of a control transfer. A packet engine hands it decoded events: a setup packet together with the direction of its data stage, IN tokens, the host's acknowledgement of a sent IN packet, and received OUT data packets with their length and data PID. For each token or packet it acts on, the block returns one handshake decision one cycle later: ACK, NAK, STALL, or DATA. DATA means "transmit the packet firmware has loaded".

Firmware works through an 8-bit control/status word and a received-byte count. It marks an IN packet as loaded and frees the receive buffer with write pulses. It ends the data stage with a data-end flag and asks for a stall with a stall-request flag. Every event firmware must handle produces a one-cycle interrupt pulse and sets a sticky pending bit. The block moves from IDLE into TX or RX on a setup packet. It moves into STATUS when firmware ends the data stage, and returns to IDLE when the status packet is accepted or a stall is sent. The largest packet is MAX_PKT bytes, 32 by default. A received packet shorter than that, including a zero-length one, is flagged as the last of the stage.

Top module: `ep0_stage_seq`

## Requirements
- R1: After reset, state_o is 0 (IDLE), csr_o is 0, rx_count_o is 0, and irq_o and resp_valid_o are low.
- R2: A setup_i pulse enters TX (state_o=1) when setup_dir_in_i is 1 and RX (state_o=2) when it is 0. It clears csr bits 0, 1 and 3, raises an interrupt, and overrides any other event in the same cycle.
- R3: In TX, an IN token gets resp_code_o 3 (DATA) when csr bit 0 (packet loaded) is set and 1 (NAK) when it is clear. The response appears with resp_valid_o high in the cycle after the token.
- R4: In TX, in_ack_i while packet loaded is set clears bit 0 and raises one interrupt for that packet. If csr bit 3 (data end) was set, the block enters STATUS (state_o=3) and clears bit 3.
- R5: In RX, an OUT packet arriving while csr bit 1 (packet received) is clear gets ACK (code 0). It sets bit 1, loads rx_count_o with its length and raises an interrupt. When bit 1 is already set, the packet gets NAK and the count is kept.
- R6: IN tokens in RX, OUT packets in TX, and every token or packet in IDLE get no response and change no state.
- R7: rx_count_o reads 0 whenever csr bit 1 is clear.
- R8: A firmware write with bit 2 set clears packet received. In RX, if data end is set or is written in the same write, the block enters STATUS.
- R9: In STATUS, an OUT packet of length 0 with the DATA1 PID gets ACK and returns the block to IDLE. A nonzero length or a DATA0 PID gets STALL. An IN token in STATUS gets NAK.
- R10: While csr bit 4 (stall request, set by writing 1 to bit 4) is set, the next token or packet that TX, RX or STATUS acts on gets STALL (code 2). The stall sets bit 5, clears bits 0, 3 and 4, returns to IDLE and raises an interrupt.
- R11: csr bit 5 (stall sent) stays set until firmware writes 1 to bit 5.
- R12: Each interrupt event gives irq_o high for exactly one cycle and sets csr bit 6, which stays set until firmware writes 1 to bit 6.
- R13: csr bit 7 is high while packet received is set and the held count is below MAX_PKT. A zero-length packet counts as short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| setup_i | input | 1 | Setup packet received (pulse) |
| setup_dir_in_i | input | 1 | 1: IN data stage follows, 0: OUT data stage |
| in_tok_i | input | 1 | IN token for endpoint zero (pulse) |
| in_ack_i | input | 1 | Host acknowledged the sent IN packet (pulse) |
| out_pkt_i | input | 1 | OUT data packet received (pulse) |
| out_len_i | input | 6 | Length of the OUT data packet in bytes |
| out_data1_i | input | 1 | OUT packet carried the DATA1 PID |
| fw_wr_i | input | 1 | Firmware write strobe |
| fw_wdata_i | input | 8 | Firmware write data (bit actions per R2 to R12) |
| resp_valid_o | output | 1 | Handshake decision valid |
| resp_code_o | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 DATA |
| state_o | output | 2 | 0 IDLE, 1 TX, 2 RX, 3 STATUS |
| csr_o | output | 8 | Control/status flags |
| rx_count_o | output | 6 | Received byte count |
| irq_o | output | 1 | Interrupt pulse |

## Verification
A wrong stage state shows at state_o in the cycle after the event that caused it. It also shows on the next token, whose response one cycle later is missing, or is NAK where DATA, ACK or STALL was expected. A stuck or lost flag appears in csr_o right after the write or event that should have changed it. A missed or doubled interrupt shows on irq_o in that same cycle. The bench therefore compares every port after every single stimulus against a model built from the requirements, so an error is reported at most one cycle after it arises.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TX     = 2'd1,
    ST_RX     = 2'd2,
    ST_STATUS = 2'd3
  } ep0_state_e;

  typedef enum logic [1:0] {
    RSP_ACK   = 2'd0,
    RSP_NAK   = 2'd1,
    RSP_STALL = 2'd2,
    RSP_DATA  = 2'd3
  } ep0_resp_e;

  localparam int CSR_W    = 8;
  localparam int B_LOAD   = 0;
  localparam int B_RCVD   = 1;
  localparam int B_CLR    = 2;
  localparam int B_DEND   = 3;
  localparam int B_SSTALL = 4;
  localparam int B_SENT   = 5;
  localparam int B_PEND   = 6;
  localparam int B_SHORT  = 7;

  // a packet below the maximum size closes the data stage
  function automatic logic is_short(int len, int max_pkt);
    return len < max_pkt;
  endfunction

  // the status packet must be empty and carry DATA1
  function automatic logic status_pkt_good(int len, logic data1);
    return (len == 0) && data1;
  endfunction

endpackage

// File: rtl/ep0_hs_decide.sv
module ep0_hs_decide
  import ep0_seq_pkg::*;
#(
  parameter int MAX_PKT = 32,
  localparam int CNT_W = $clog2(MAX_PKT + 1)
) (
  input  ep0_state_e       state_i,
  input  logic             in_tok_i,
  input  logic             out_pkt_i,
  input  logic [CNT_W-1:0] out_len_i,
  input  logic             out_data1_i,
  input  logic             stall_req_i,
  input  logic             loaded_i,
  input  logic             rcvd_i,
  output logic             fire_o,
  output ep0_resp_e        code_o,
  output logic             stall_o,
  output logic             accept_o,
  output logic             status_ok_o
);

  always_comb begin
    fire_o      = 1'b0;
    code_o      = RSP_NAK;
    stall_o     = 1'b0;
    accept_o    = 1'b0;
    status_ok_o = 1'b0;
    case (state_i)
      ST_TX: begin
        if (in_tok_i) begin
          fire_o = 1'b1;
          if (stall_req_i) begin
            code_o  = RSP_STALL;
            stall_o = 1'b1;
          end else if (loaded_i) begin
            code_o = RSP_DATA;
          end
        end
      end
      ST_RX: begin
        if (out_pkt_i) begin
          fire_o = 1'b1;
          if (stall_req_i) begin
            code_o  = RSP_STALL;
            stall_o = 1'b1;
          end else if (!rcvd_i) begin
            code_o   = RSP_ACK;
            accept_o = 1'b1;
          end
        end
      end
      ST_STATUS: begin
        if (out_pkt_i) begin
          fire_o = 1'b1;
          if (stall_req_i || !status_pkt_good(32'(out_len_i), out_data1_i)) begin
            code_o  = RSP_STALL;
            stall_o = 1'b1;
          end else begin
            code_o      = RSP_ACK;
            status_ok_o = 1'b1;
          end
        end else if (in_tok_i) begin
          fire_o = 1'b1;
          if (stall_req_i) begin
            code_o  = RSP_STALL;
            stall_o = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ep0_irq_ctl.sv
module ep0_irq_ctl #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             clr_i,
  output logic             irq_o,
  output logic             pend_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      irq_o  <= |src_i;
      pend_o <= (pend_o & ~clr_i) | (|src_i);
    end
  end

endmodule

// File: rtl/ep0_stage_seq.sv
module ep0_stage_seq
  import ep0_seq_pkg::*;
#(
  parameter int MAX_PKT = 32,
  localparam int CNT_W = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_i,
  input  logic             setup_dir_in_i,
  input  logic             in_tok_i,
  input  logic             in_ack_i,
  input  logic             out_pkt_i,
  input  logic [CNT_W-1:0] out_len_i,
  input  logic             out_data1_i,
  input  logic             fw_wr_i,
  input  logic [CSR_W-1:0] fw_wdata_i,
  output logic             resp_valid_o,
  output logic [1:0]       resp_code_o,
  output logic [1:0]       state_o,
  output logic [CSR_W-1:0] csr_o,
  output logic [CNT_W-1:0] rx_count_o,
  output logic             irq_o
);

  localparam int N_IRQ = 4;

  ep0_state_e       state_q;
  ep0_resp_e        code_q;
  ep0_resp_e        hs_code;
  logic             resp_valid_q;
  logic             loaded_q, rcvd_q, dend_q, sstall_q, sent_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend;

  // named internal events, also observed by the checker
  logic hs_fire, ev_stall, ev_rx_accept, ev_status_ok, ev_tx_sent, ev_rx_done;
  logic w_load, w_clr, w_dend, w_sstall, w_sent_clr, w_pend_clr;
  logic tok_gated, pkt_gated;

  assign w_load     = fw_wr_i & fw_wdata_i[B_LOAD];
  assign w_clr      = fw_wr_i & fw_wdata_i[B_CLR];
  assign w_dend     = fw_wr_i & fw_wdata_i[B_DEND];
  assign w_sstall   = fw_wr_i & fw_wdata_i[B_SSTALL];
  assign w_sent_clr = fw_wr_i & fw_wdata_i[B_SENT];
  assign w_pend_clr = fw_wr_i & fw_wdata_i[B_PEND];

  assign tok_gated = in_tok_i & ~setup_i;
  assign pkt_gated = out_pkt_i & ~setup_i;

  assign ev_tx_sent = ~setup_i & (state_q == ST_TX) & in_ack_i & loaded_q;
  assign ev_rx_done = ~setup_i & (state_q == ST_RX) & w_clr & (dend_q | w_dend);

  ep0_hs_decide #(.MAX_PKT(MAX_PKT)) hs_i (
    .state_i     (state_q),
    .in_tok_i    (tok_gated),
    .out_pkt_i   (pkt_gated),
    .out_len_i   (out_len_i),
    .out_data1_i (out_data1_i),
    .stall_req_i (sstall_q),
    .loaded_i    (loaded_q),
    .rcvd_i      (rcvd_q),
    .fire_o      (hs_fire),
    .code_o      (hs_code),
    .stall_o     (ev_stall),
    .accept_o    (ev_rx_accept),
    .status_ok_o (ev_status_ok)
  );

  ep0_irq_ctl #(.N_SRC(N_IRQ)) irq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  ({setup_i, ev_tx_sent, ev_rx_accept, ev_stall}),
    .clr_i  (w_pend_clr),
    .irq_o  (irq_o),
    .pend_o (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      code_q       <= RSP_ACK;
      resp_valid_q <= 1'b0;
      loaded_q     <= 1'b0;
      rcvd_q       <= 1'b0;
      dend_q       <= 1'b0;
      sstall_q     <= 1'b0;
      sent_q       <= 1'b0;
      cnt_q        <= '0;
    end else begin
      resp_valid_q <= hs_fire;
      code_q       <= hs_code;
      // firmware actions first, then events take precedence
      if (w_load)     loaded_q <= 1'b1;
      if (w_clr)      rcvd_q   <= 1'b0;
      if (w_dend)     dend_q   <= 1'b1;
      if (w_sstall)   sstall_q <= 1'b1;
      if (w_sent_clr) sent_q   <= 1'b0;
      if (ev_rx_accept) begin
        rcvd_q <= 1'b1;
        cnt_q  <= out_len_i;
      end
      if (ev_tx_sent) begin
        loaded_q <= 1'b0;
        if (dend_q) begin
          state_q <= ST_STATUS;
          dend_q  <= 1'b0;
        end
      end
      if (ev_rx_done) begin
        state_q <= ST_STATUS;
        dend_q  <= 1'b0;
      end
      if (ev_status_ok) state_q <= ST_IDLE;
      if (ev_stall) begin
        state_q  <= ST_IDLE;
        sstall_q <= 1'b0;
        sent_q   <= 1'b1;
        loaded_q <= 1'b0;
        dend_q   <= 1'b0;
      end
      if (setup_i) begin
        state_q  <= setup_dir_in_i ? ST_TX : ST_RX;
        loaded_q <= 1'b0;
        rcvd_q   <= 1'b0;
        dend_q   <= 1'b0;
      end
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_code_o  = code_q;
  assign state_o      = state_q;
  assign rx_count_o   = rcvd_q ? cnt_q : '0;

  always_comb begin
    csr_o           = '0;
    csr_o[B_LOAD]   = loaded_q;
    csr_o[B_RCVD]   = rcvd_q;
    csr_o[B_DEND]   = dend_q;
    csr_o[B_SSTALL] = sstall_q;
    csr_o[B_SENT]   = sent_q;
    csr_o[B_PEND]   = pend;
    csr_o[B_SHORT]  = rcvd_q & is_short(32'(cnt_q), MAX_PKT);
  end

endmodule

// File: rtl/ep0_stage_seq_chk.sv
module ep0_stage_seq_chk #(
  parameter int MAX_PKT = 32,
  localparam int CNT_W = $clog2(MAX_PKT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             setup_i,
  input logic             in_tok_i,
  input logic             in_ack_i,
  input logic             out_pkt_i,
  input logic [CNT_W-1:0] out_len_i,
  input logic             fw_wr_i,
  input logic             resp_valid_o,
  input logic [1:0]       resp_code_o,
  input logic [1:0]       state_o,
  input logic [7:0]       csr_o,
  input logic [CNT_W-1:0] rx_count_o,
  input logic             irq_o,
  input logic             ev_status_ok
);

  assert_nak_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && in_tok_i && !setup_i && !csr_o[0] && !csr_o[4])
      |=> (resp_valid_o && resp_code_o == 2'd1));

  assert_tx_sent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && in_ack_i && csr_o[0] && !setup_i && !fw_wr_i)
      |=> (!csr_o[0] && irq_o));

  assert_rx_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_o[1]) |-> (rx_count_o == $past(out_len_i) && $past(out_pkt_i)));

  assert_rx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && in_tok_i && !out_pkt_i && !setup_i) |=> !resp_valid_o);

  assert_status_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_status_ok |=> (state_o == 2'd0 && resp_valid_o && resp_code_o == 2'd0));

  assert_stall_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_code_o == 2'd2) |-> (state_o == 2'd0 && csr_o[5] && !csr_o[4]));

  assert_irq_pend_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> csr_o[6]);

endmodule

bind ep0_stage_seq ep0_stage_seq_chk #(.MAX_PKT(MAX_PKT)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .setup_i      (setup_i),
  .in_tok_i     (in_tok_i),
  .in_ack_i     (in_ack_i),
  .out_pkt_i    (out_pkt_i),
  .out_len_i    (out_len_i),
  .fw_wr_i      (fw_wr_i),
  .resp_valid_o (resp_valid_o),
  .resp_code_o  (resp_code_o),
  .state_o      (state_o),
  .csr_o        (csr_o),
  .rx_count_o   (rx_count_o),
  .irq_o        (irq_o),
  .ev_status_ok (ev_status_ok)
);

// File: tb/ep0_stage_seq_tb.sv
`timescale 1ns/1ps
module ep0_stage_seq_tb_top;

  localparam int MAXP = 32;
  localparam int CW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_i = 0, setup_dir_in_i = 0, in_tok_i = 0, in_ack_i = 0, out_pkt_i = 0;
  logic [CW-1:0] out_len_i = '0;
  logic out_data1_i = 0, fw_wr_i = 0;
  logic [7:0] fw_wdata_i = '0;
  logic resp_valid_o, irq_o;
  logic [1:0] resp_code_o, state_o;
  logic [7:0] csr_o;
  logic [CW-1:0] rx_count_o;

  always #2 clk = ~clk;

  ep0_stage_seq #(.MAX_PKT(MAXP)) dut_i (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model
  int m_state;
  bit m_loaded, m_rcvd, m_dend, m_sstall, m_sent, m_pend;
  int m_cnt;
  bit e_rv, e_irq;
  int e_code;

  function automatic logic [7:0] exp_csr();
    logic [7:0] c;
    c = '0;
    c[0] = m_loaded; c[1] = m_rcvd; c[3] = m_dend; c[4] = m_sstall;
    c[5] = m_sent;   c[6] = m_pend; c[7] = m_rcvd && (m_cnt < MAXP);
    return c;
  endfunction

  function automatic void m_reset();
    m_state = 0; m_loaded = 0; m_rcvd = 0; m_dend = 0; m_sstall = 0;
    m_sent = 0; m_pend = 0; m_cnt = 0;
  endfunction

  function automatic void m_begin();
    e_rv = 0; e_irq = 0; e_code = 0;
  endfunction

  function automatic void m_stall();
    e_rv = 1; e_code = 2; e_irq = 1;
    m_state = 0; m_sstall = 0; m_sent = 1; m_loaded = 0; m_dend = 0;
  endfunction

  function automatic void m_setup(bit dir);
    m_state = dir ? 1 : 2; m_loaded = 0; m_rcvd = 0; m_dend = 0; e_irq = 1;
  endfunction

  function automatic void m_in_tok();
    if (m_state == 1) begin
      if (m_sstall) m_stall();
      else begin e_rv = 1; e_code = m_loaded ? 3 : 1; end
    end else if (m_state == 3) begin
      if (m_sstall) m_stall();
      else begin e_rv = 1; e_code = 1; end
    end
  endfunction

  function automatic void m_in_ack();
    if (m_state == 1 && m_loaded) begin
      m_loaded = 0; e_irq = 1;
      if (m_dend) begin m_state = 3; m_dend = 0; end
    end
  endfunction

  function automatic void m_out_pkt(int len, bit d1);
    if (m_state == 2) begin
      if (m_sstall) m_stall();
      else if (m_rcvd) begin e_rv = 1; e_code = 1; end
      else begin e_rv = 1; e_code = 0; m_rcvd = 1; m_cnt = len; e_irq = 1; end
    end else if (m_state == 3) begin
      if (m_sstall || len != 0 || !d1) m_stall();
      else begin e_rv = 1; e_code = 0; m_state = 0; end
    end
  endfunction

  function automatic void m_write(logic [7:0] w);
    if (w[0]) m_loaded = 1;
    if (w[2]) m_rcvd = 0;
    if (w[3]) m_dend = 1;
    if (w[4]) m_sstall = 1;
    if (w[5]) m_sent = 0;
    if (w[6]) m_pend = 0;
    if (m_state == 2 && w[2] && m_dend) begin m_state = 3; m_dend = 0; end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic verify(input string req);
    if (e_irq) m_pend = 1;
    chk(resp_valid_o == e_rv, req, "resp_valid", resp_valid_o, e_rv);
    if (e_rv) chk(resp_code_o == e_code[1:0], req, "resp_code", resp_code_o, e_code);
    chk(state_o == m_state[1:0], req, "state", state_o, m_state);
    chk(csr_o == exp_csr(), req, "csr", csr_o, exp_csr());
    chk(rx_count_o == (m_rcvd ? m_cnt[CW-1:0] : '0), req, "rx_count",
        rx_count_o, m_rcvd ? m_cnt : 0);
    chk(irq_o == e_irq, req, "irq", irq_o, e_irq);
  endtask

  task automatic finish_step(input string req);
    @(negedge clk);
    setup_i = 0; in_tok_i = 0; in_ack_i = 0; out_pkt_i = 0; fw_wr_i = 0;
    verify(req);
  endtask

  task automatic do_setup(input bit dir, input string req);
    m_begin(); setup_i = 1; setup_dir_in_i = dir; m_setup(dir); finish_step(req);
  endtask
  task automatic do_in(input string req);
    m_begin(); in_tok_i = 1; m_in_tok(); finish_step(req);
  endtask
  task automatic do_ack(input string req);
    m_begin(); in_ack_i = 1; m_in_ack(); finish_step(req);
  endtask
  task automatic do_out(input int len, input bit d1, input string req);
    m_begin(); out_pkt_i = 1; out_len_i = len[CW-1:0]; out_data1_i = d1;
    m_out_pkt(len, d1); finish_step(req);
  endtask
  task automatic do_wr(input logic [7:0] w, input string req);
    m_begin(); fw_wr_i = 1; fw_wdata_i = w; m_write(w); finish_step(req);
  endtask
  task automatic do_idle(input string req);
    m_begin(); finish_step(req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0e00));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_begin();
    @(negedge clk);
    verify("R1");

    // IN data stage
    do_in("R6");                    // IDLE ignores tokens
    do_setup(1, "R2");
    do_idle("R12");                 // interrupt was a single pulse
    do_in("R3");                    // nothing loaded -> NAK
    do_wr(8'h01, "R3");
    do_in("R3");                    // loaded -> DATA
    do_out(5, 1, "R6");             // OUT ignored in TX
    do_ack("R4");
    do_wr(8'h09, "R4");             // load + data end
    do_ack("R4");                   // -> STATUS
    do_in("R9");                    // IN in status -> NAK
    do_out(0, 1, "R9");             // good status -> IDLE

    // OUT data stage, exact multiple of the packet size
    do_setup(0, "R2");
    do_in("R6");
    do_out(32, 0, "R5");
    do_out(7, 1, "R5");             // buffer full -> NAK
    do_wr(8'h04, "R7");
    do_out(0, 1, "R13");            // zero-length closes stage
    do_wr(8'h0C, "R8");             // clear + data end -> STATUS
    do_out(0, 0, "R9");             // DATA0 status -> STALL
    do_wr(8'h00, "R11");
    do_wr(8'h20, "R11");
    do_wr(8'h40, "R12");

    // stall request, and a bad-length status
    do_setup(1, "R2");
    do_wr(8'h10, "R10");
    do_in("R10");
    do_setup(0, "R2");
    do_out(3, 1, "R13");
    do_wr(8'h0C, "R8");
    do_out(4, 1, "R9");

    // constrained random traffic
    for (int i = 0; i < 1500; i++) begin
      int sel;
      logic [7:0] w;
      sel = $urandom_range(0, 11);
      case (sel)
        0:       do_setup(1'($urandom_range(0, 1)), "R2");
        1, 2:    do_in("R3/R9/R10");
        3:       do_ack("R4");
        4, 5, 6: begin
          int len;
          len = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, MAXP));
          do_out(len, 1'($urandom_range(0, 3) != 0), "R5/R9/R13");
        end
        7, 8, 9: begin
          w = 8'($urandom) & 8'h6F;
          if ($urandom_range(0, 9) == 0) w[4] = 1'b1;
          do_wr(w, "R8/R11/R12");
        end
        default: do_idle("R12");
      endcase
    end
    summary();
  end

endmodule